// File: doc/BRIEF.md
# Load/Store Address Buffer

This block holds memory operations between dispatch and the memory port in an out-of-order datapath. Each dispatched load or store takes one slot. The slot captures its base and data operands either as finished values or as producer tags. A pending operand is filled when the matching tag appears on the broadcast result bus. Once the base is known, the slot forms the effective address, which is the base plus a sign-extended 16-bit offset, and keeps it. Loads need only the address. Stores also need their data value before they can go out.

The oldest slot is the only one that may address memory, so requests leave strictly in dispatch order. A load that is older than nothing but waits behind an unfinished store therefore stays put. A store performs its memory write as its final step and returns nothing. A load's read data comes back one cycle after the port accepts it, and one cycle after that the block broadcasts the load as a destination-tag/value pair.

Dispatch uses a valid/ready handshake. An operation is taken on a clock edge where `disp_valid` and `disp_ready` are both high. `disp_ready` is low exactly when every slot is occupied, and `buf_full` mirrors that state for issue logic. The memory request also uses valid/ready. While `mem_req_valid` is high and `mem_req_ready` is low, the request fields hold still and the request is not withdrawn. The result broadcast has no back-pressure: consumers must take it in the cycle it is shown.

Top module: `ldst_addr_buffer`

## Requirements
- R1: Out of reset the buffer is empty: `mem_req_valid` and `res_valid` are low, `buf_full` is low and `disp_ready` is high.
- R2: The request address equals the base value plus the 16-bit offset sign-extended from its bit 15, modulo 2^32.
- R3: A slot whose base operand is a pending tag makes no memory request until a bus broadcast carries that tag; the address is then formed from the broadcast value.
- R4: A store makes no memory request until its data operand is real; `mem_req_write` is 1 for stores, 0 for loads, and `mem_req_wdata` carries the store value.
- R5: Requests leave in dispatch order: a younger ready load is not presented while an older store or load is still waiting.
- R6: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with address, write flag and data unchanged.
- R7: A load accepted at edge k has its read data sampled from `mem_rdata` at edge k+1, and `res_valid` is high for exactly one cycle after edge k+1, with `res_tag` equal to the load's destination tag and `res_value` equal to that read data.
- R8: With all 4 slots occupied, `buf_full` is high and `disp_ready` is low, and a dispatch offered in that state is not taken.
- R9: A broadcast whose tag matches a pending operand in the same cycle as that operation's dispatch fills that operand.
- R10: A broadcast whose tag matches no pending operand leaves a waiting slot waiting.
- R11: An accepted store produces no result broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | Buffer can take a dispatch |
| disp_store | input | 1 | 1 = store, 0 = load |
| disp_offset | input | 16 | Signed address offset |
| disp_dest | input | 4 | Destination tag broadcast with a load result |
| disp_base_rdy | input | 1 | Base operand is a real value |
| disp_base_tag | input | 4 | Producer tag of a pending base |
| disp_base_val | input | 32 | Base value when real |
| disp_data_rdy | input | 1 | Store data operand is a real value |
| disp_data_tag | input | 4 | Producer tag of pending store data |
| disp_data_val | input | 32 | Store data when real |
| buf_full | output | 1 | All slots occupied |
| cdb_valid | input | 1 | Broadcast bus carries a result |
| cdb_tag | input | 4 | Tag of the broadcast result |
| cdb_value | input | 32 | Value of the broadcast result |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Effective address |
| mem_req_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read is accepted |
| res_valid | output | 1 | Load result broadcast |
| res_tag | output | 4 | Destination tag of the load result |
| res_value | output | 32 | Loaded value |

## Verification
The bench targets sign extension of negative and boundary offsets and address wrap past 2^32. An adder that zero-extends or truncates would present a wrong address. It places a ready load behind a store whose data is missing; a design that scans for any ready slot would send the load first. It fills every slot and then offers one more dispatch; an off-by-one full flag would overwrite a live slot and add a fifth result. It also broadcasts a tag in the same cycle as the dispatch that waits on it, and broadcasts an unrelated tag. A design without the dispatch-time bypass would hang forever, and one that ignores the tag compare would wake early with a wrong address.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } mem_op_e;
endpackage

// File: rtl/lsb_ring.sv
module lsb_ring #(
  parameter int DEPTH = 4,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  output logic [IDXW-1:0] head,
  output logic [IDXW-1:0] tail,
  output logic            full
);
  logic [CNTW-1:0] count;

  function automatic logic [IDXW-1:0] step(input logic [IDXW-1:0] p);
    return (p == IDXW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= step(tail);
      if (pop)  head <= step(head);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full = (count == CNTW'(DEPTH));
endmodule

// File: rtl/lsb_slot.sv
module lsb_slot
  import lsb_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int TAGW = 4,
  parameter int OFFW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc,
  input  mem_op_e         a_op,
  input  logic [OFFW-1:0] a_off,
  input  logic [TAGW-1:0] a_dest,
  input  logic            a_base_rdy,
  input  logic [TAGW-1:0] a_base_tag,
  input  logic [DW-1:0]   a_base_val,
  input  logic            a_data_rdy,
  input  logic [TAGW-1:0] a_data_tag,
  input  logic [DW-1:0]   a_data_val,
  input  logic            cdb_valid,
  input  logic [TAGW-1:0] cdb_tag,
  input  logic [DW-1:0]   cdb_value,
  input  logic            release_i,
  output logic            busy,
  output mem_op_e         op,
  output logic            addr_ok,
  output logic [AW-1:0]   addr,
  output logic            data_ok,
  output logic [DW-1:0]   data,
  output logic [TAGW-1:0] dest
);
  logic [OFFW-1:0] off_q;
  logic [TAGW-1:0] base_tag_q, data_tag_q;
  logic            base_hit, data_hit, a_base_hit, a_data_hit;

  function automatic logic [AW-1:0] agen(input logic [DW-1:0] b, input logic [OFFW-1:0] o);
    return b[AW-1:0] + {{(AW - OFFW){o[OFFW-1]}}, o};
  endfunction

  assign base_hit   = cdb_valid && (cdb_tag == base_tag_q);
  assign data_hit   = cdb_valid && (cdb_tag == data_tag_q);
  assign a_base_hit = cdb_valid && (cdb_tag == a_base_tag);
  assign a_data_hit = cdb_valid && (cdb_tag == a_data_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      op         <= OP_LOAD;
      addr_ok    <= 1'b0;
      addr       <= '0;
      data_ok    <= 1'b0;
      data       <= '0;
      dest       <= '0;
      off_q      <= '0;
      base_tag_q <= '0;
      data_tag_q <= '0;
    end else if (alloc) begin
      busy       <= 1'b1;
      op         <= a_op;
      dest       <= a_dest;
      off_q      <= a_off;
      base_tag_q <= a_base_tag;
      data_tag_q <= a_data_tag;
      if (a_base_rdy) begin
        addr_ok <= 1'b1;
        addr    <= agen(a_base_val, a_off);
      end else if (a_base_hit) begin
        addr_ok <= 1'b1;
        addr    <= agen(cdb_value, a_off);
      end else begin
        addr_ok <= 1'b0;
      end
      if (a_op == OP_LOAD || a_data_rdy) begin
        data_ok <= 1'b1;
        data    <= a_data_val;
      end else if (a_data_hit) begin
        data_ok <= 1'b1;
        data    <= cdb_value;
      end else begin
        data_ok <= 1'b0;
      end
    end else begin
      if (release_i) busy <= 1'b0;
      if (busy && !addr_ok && base_hit) begin
        addr_ok <= 1'b1;
        addr    <= agen(cdb_value, off_q);
      end
      if (busy && !data_ok && data_hit) begin
        data_ok <= 1'b1;
        data    <= cdb_value;
      end
    end
  end
endmodule

// File: rtl/lsb_resp.sv
module lsb_resp #(
  parameter int DW   = 32,
  parameter int TAGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire_load,
  input  logic [TAGW-1:0] fire_tag,
  input  logic [DW-1:0]   mem_rdata,
  output logic            res_valid,
  output logic [TAGW-1:0] res_tag,
  output logic [DW-1:0]   res_value
);
  logic            pend;
  logic [TAGW-1:0] pend_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_tag  <= '0;
      res_valid <= 1'b0;
      res_tag   <= '0;
      res_value <= '0;
    end else begin
      pend      <= fire_load;
      pend_tag  <= fire_tag;
      res_valid <= pend;
      if (pend) begin
        res_tag   <= pend_tag;
        res_value <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/ldst_addr_buffer.sv
module ldst_addr_buffer
  import lsb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TAGW  = 4,
  parameter int OFFW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_valid,
  output logic            disp_ready,
  input  logic            disp_store,
  input  logic [OFFW-1:0] disp_offset,
  input  logic [TAGW-1:0] disp_dest,
  input  logic            disp_base_rdy,
  input  logic [TAGW-1:0] disp_base_tag,
  input  logic [DW-1:0]   disp_base_val,
  input  logic            disp_data_rdy,
  input  logic [TAGW-1:0] disp_data_tag,
  input  logic [DW-1:0]   disp_data_val,
  output logic            buf_full,
  input  logic            cdb_valid,
  input  logic [TAGW-1:0] cdb_tag,
  input  logic [DW-1:0]   cdb_value,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr,
  output logic [DW-1:0]   mem_req_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            res_valid,
  output logic [TAGW-1:0] res_tag,
  output logic [DW-1:0]   res_value
);
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDXW-1:0] head, tail;
  logic            push, pop, full;
  mem_op_e         disp_op;

  logic            busy_v    [DEPTH];
  mem_op_e         op_v      [DEPTH];
  logic            addr_ok_v [DEPTH];
  logic [AW-1:0]   addr_v    [DEPTH];
  logic            data_ok_v [DEPTH];
  logic [DW-1:0]   data_v    [DEPTH];
  logic [TAGW-1:0] dest_v    [DEPTH];

  logic head_go;

  assign disp_op    = disp_store ? OP_STORE : OP_LOAD;
  assign disp_ready = !full;
  assign buf_full   = full;
  assign push       = disp_valid && disp_ready;
  assign pop        = mem_req_valid && mem_req_ready;

  lsb_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head(head), .tail(tail), .full(full)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    lsb_slot #(.AW(AW), .DW(DW), .TAGW(TAGW), .OFFW(OFFW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (push && (tail == IDXW'(i))),
      .a_op       (disp_op),
      .a_off      (disp_offset),
      .a_dest     (disp_dest),
      .a_base_rdy (disp_base_rdy),
      .a_base_tag (disp_base_tag),
      .a_base_val (disp_base_val),
      .a_data_rdy (disp_data_rdy),
      .a_data_tag (disp_data_tag),
      .a_data_val (disp_data_val),
      .cdb_valid  (cdb_valid),
      .cdb_tag    (cdb_tag),
      .cdb_value  (cdb_value),
      .release_i  (pop && (head == IDXW'(i))),
      .busy       (busy_v[i]),
      .op         (op_v[i]),
      .addr_ok    (addr_ok_v[i]),
      .addr       (addr_v[i]),
      .data_ok    (data_ok_v[i]),
      .data       (data_v[i]),
      .dest       (dest_v[i])
    );
  end

  always_comb begin
    head_go       = busy_v[head] && addr_ok_v[head] &&
                    ((op_v[head] == OP_LOAD) || data_ok_v[head]);
    mem_req_valid = head_go;
    mem_req_write = (op_v[head] == OP_STORE);
    mem_req_addr  = addr_v[head];
    mem_req_wdata = data_v[head];
  end

  lsb_resp #(.DW(DW), .TAGW(TAGW)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_load (pop && !mem_req_write),
    .fire_tag  (dest_v[head]),
    .mem_rdata (mem_rdata),
    .res_valid (res_valid),
    .res_tag   (res_tag),
    .res_value (res_value)
  );
endmodule

// File: rtl/lsb_checker.sv
module lsb_checker #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          disp_valid,
  input logic          disp_ready,
  input logic          buf_full,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          res_valid
);
  localparam int CW = $clog2(DEPTH + 1) + 1;
  logic [CW-1:0] occ;
  logic          take, fire, load_fire;

  assign take      = disp_valid && disp_ready;
  assign fire      = mem_req_valid && mem_req_ready;
  assign load_fire = fire && !mem_req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + CW'(take) - CW'(fire);
  end

  assert_idle_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !mem_req_valid);

  assert_full_matches_occupancy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full == (occ == CW'(DEPTH)));

  assert_request_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  assert_load_gives_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |-> ##2 res_valid);

  assert_result_only_from_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(load_fire, 2));
endmodule

bind ldst_addr_buffer lsb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .buf_full(buf_full), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .res_valid(res_valid)
);

// File: tb/ldst_addr_buffer_test.sv
`timescale 1ns/1ps
module ldst_addr_buffer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        disp_valid, disp_ready, disp_store;
  logic [15:0] disp_offset;
  logic [3:0]  disp_dest, disp_base_tag, disp_data_tag;
  logic        disp_base_rdy, disp_data_rdy;
  logic [31:0] disp_base_val, disp_data_val;
  logic        buf_full;
  logic        cdb_valid;
  logic [3:0]  cdb_tag;
  logic [31:0] cdb_value;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rdata;
  logic        res_valid;
  logic [3:0]  res_tag;
  logic [31:0] res_value;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ldst_addr_buffer uut (.*);

  localparam int NV = 5;
  localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h0000_2000, 32'hFFFF_FFF0, 32'h8000_0000, 32'h1234_5678};
  localparam logic [15:0] V_OFF  [NV] = '{16'h0010, 16'hFFF0, 16'h0020, 16'h8000, 16'h7FFF};
  localparam logic [31:0] V_ADDR [NV] = '{32'h0000_1010, 32'h0000_1FF0, 32'h0000_0010, 32'h7FFF_8000, 32'h1234_D677};
  localparam logic [31:0] V_RD   [NV] = '{32'hA5A5_0001, 32'h0BAD_F00D, 32'h1111_2222, 32'hFFFF_0000, 32'h0000_0007};

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic idle_in();
    disp_valid = 0; disp_store = 0; disp_offset = '0; disp_dest = '0;
    disp_base_rdy = 0; disp_base_tag = '0; disp_base_val = '0;
    disp_data_rdy = 0; disp_data_tag = '0; disp_data_val = '0;
    cdb_valid = 0; cdb_tag = '0; cdb_value = '0;
    mem_req_ready = 0; mem_rdata = '0;
  endtask

  task automatic disp(input logic st, input logic brdy, input logic [31:0] bval, input logic [3:0] btag,
                      input logic drdy, input logic [31:0] dval, input logic [3:0] dtag,
                      input logic [15:0] off, input logic [3:0] dst);
    disp_store = st; disp_base_rdy = brdy; disp_base_val = bval; disp_base_tag = btag;
    disp_data_rdy = drdy; disp_data_val = dval; disp_data_tag = dtag;
    disp_offset = off; disp_dest = dst; disp_valid = 1;
    @(negedge clk);
    disp_valid = 0;
  endtask

  task automatic drain_load(input logic [3:0] tag, input logic [31:0] rd);
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0; mem_rdata = rd;
    @(negedge clk);
    chk("R7 res_valid", 32'(res_valid), 32'd1);
    chk("R7 res_tag", 32'(res_tag), 32'(tag));
    chk("R7 res_value", res_value, rd);
    @(negedge clk);
    chk("R7 single pulse", 32'(res_valid), 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
    chk("R1 res_valid", 32'(res_valid), 32'd0);
    chk("R1 buf_full", 32'(buf_full), 32'd0);
    chk("R1 disp_ready", 32'(disp_ready), 32'd1);

    // R2: address table, loads with real base
    for (int i = 0; i < NV; i++) begin
      disp(1'b0, 1'b1, V_BASE[i], 4'd0, 1'b0, '0, 4'd0, V_OFF[i], 4'(i + 1));
      chk("R2 req valid", 32'(mem_req_valid), 32'd1);
      chk("R2 addr", mem_req_addr, V_ADDR[i]);
      chk("R4 read flag", 32'(mem_req_write), 32'd0);
      drain_load(4'(i + 1), V_RD[i]);
    end

    // R3 / R10: pending base woken only by its own tag
    disp(1'b0, 1'b0, '0, 4'd5, 1'b0, '0, 4'd0, 16'h0004, 4'd2);
    chk("R3 waits for base", 32'(mem_req_valid), 32'd0);
    cdb_valid = 1; cdb_tag = 4'd6; cdb_value = 32'h9999_0000;
    @(negedge clk);
    cdb_valid = 0;
    chk("R10 foreign tag ignored", 32'(mem_req_valid), 32'd0);
    cdb_valid = 1; cdb_tag = 4'd5; cdb_value = 32'h0000_3000;
    @(negedge clk);
    cdb_valid = 0;
    chk("R3 woken valid", 32'(mem_req_valid), 32'd1);
    chk("R3 woken addr", mem_req_addr, 32'h0000_3004);
    drain_load(4'd2, 32'hCAFE_0003);

    // R4 / R5 / R6 / R11: store waiting for data blocks a younger load
    disp(1'b1, 1'b1, 32'h0000_8000, 4'd0, 1'b0, '0, 4'd7, 16'h0000, 4'd0);
    disp(1'b0, 1'b1, 32'h0000_9000, 4'd0, 1'b0, '0, 4'd0, 16'h0010, 4'd8);
    chk("R4 store waits for data", 32'(mem_req_valid), 32'd0);
    chk("R5 younger load held", 32'(mem_req_valid), 32'd0);
    cdb_valid = 1; cdb_tag = 4'd7; cdb_value = 32'hDEAD_BEEF;
    @(negedge clk);
    cdb_valid = 0;
    chk("R4 store valid", 32'(mem_req_valid), 32'd1);
    chk("R4 write flag", 32'(mem_req_write), 32'd1);
    chk("R4 wdata", mem_req_wdata, 32'hDEAD_BEEF);
    chk("R5 store first addr", mem_req_addr, 32'h0000_8000);
    @(negedge clk);
    chk("R6 held valid", 32'(mem_req_valid), 32'd1);
    chk("R6 held addr", mem_req_addr, 32'h0000_8000);
    chk("R6 held wdata", mem_req_wdata, 32'hDEAD_BEEF);
    mem_req_ready = 1;
    @(negedge clk);
    chk("R5 load next valid", 32'(mem_req_valid), 32'd1);
    chk("R5 load next write", 32'(mem_req_write), 32'd0);
    chk("R5 load next addr", mem_req_addr, 32'h0000_9010);
    @(negedge clk);
    mem_req_ready = 0; mem_rdata = 32'h0055_AA00;
    chk("R11 no result from store", 32'(res_valid), 32'd0);
    @(negedge clk);
    chk("R7 load after store valid", 32'(res_valid), 32'd1);
    chk("R7 load after store tag", 32'(res_tag), 32'd8);
    chk("R7 load after store value", res_value, 32'h0055_AA00);
    @(negedge clk);

    // R8: fill all slots, offer one more
    for (int k = 0; k < 4; k++)
      disp(1'b0, 1'b0, '0, 4'd9, 1'b0, '0, 4'd0, 16'(4 * k), 4'(10 + k));
    chk("R8 buf_full", 32'(buf_full), 32'd1);
    chk("R8 disp_ready", 32'(disp_ready), 32'd0);
    cdb_valid = 1; cdb_tag = 4'd9; cdb_value = 32'h0000_4000;
    disp(1'b0, 1'b1, 32'h0000_7000, 4'd0, 1'b0, '0, 4'd0, 16'h0100, 4'd14);
    cdb_valid = 0;
    begin
      int nres = 0;
      mem_rdata = 32'h0000_1234;
      for (int k = 0; k < 8; k++) begin
        if (k < 4) begin
          chk("R5 drain order addr", mem_req_addr, 32'h0000_4000 + 32'(4 * k));
          mem_req_ready = 1;
        end
        if (k == 4) begin
          mem_req_ready = 0;
          chk("R8 extra dispatch dropped", 32'(mem_req_valid), 32'd0);
          chk("R8 not full after drain", 32'(buf_full), 32'd0);
        end
        if (res_valid) nres++;
        @(negedge clk);
      end
      chk("R8 result count", 32'(nres), 32'd4);
    end

    // R9: broadcast in the dispatch cycle
    cdb_valid = 1; cdb_tag = 4'd3; cdb_value = 32'h0000_5000;
    disp(1'b0, 1'b0, '0, 4'd3, 1'b0, '0, 4'd0, 16'h0008, 4'd4);
    cdb_valid = 0;
    chk("R9 bypass valid", 32'(mem_req_valid), 32'd1);
    chk("R9 bypass addr", mem_req_addr, 32'h0000_5008);
    drain_load(4'd4, 32'h0000_0999);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule